// File: doc/BRIEF.md
# Serial Clock and Word-Length Timer

This block is a programmable timer for a flexible serial engine. Its compare word is split into two bytes. The low byte sets a half-period divider. Each time the divider expires, the generated serial clock toggles and the divider reloads. The high byte counts serial clock edges per word. Software programs it to twice the bit count minus one, so an 8-bit word uses 0x0F. The timer emits a one-cycle shift strobe on every falling serial clock edge, which tells a shifter when to move. At the end of each word it emits a one-cycle compare flag.

The timer idles with its clock low until its trigger is active. The trigger has a selectable polarity, so an internal status flag can be used inverted. At the end of a word the timer can stop, or it can reload and carry on with the next word. Optional lead and trail bits add one full bit period, two divider expiries with the clock held, before and after the data edges.

A wide mode joins both bytes into one 16-bit counter. In this mode the counter toggles the clock and raises the flag on each expiry, and it gives no strobe. In either mode the counter can be decremented by rising edges of an external pin instead of by every module clock cycle.

Top module: `sbaud_timer`

## Requirements
- R1: After reset, sclk_o, shift_stb_o and cmp_flag_o are 0 and the timer is idle.
- R2: An idle timer starts on the first clock edge at which trig_i XOR trig_inv_i is 1. While that value is 0 the timer stays idle, with sclk_o at 0 and no flag.
- R3: In split mode (mode_wide_i=0), sclk_o toggles once every L+1 counting ticks, where L = cmp_i[7:0]. The low byte reloads from L at each expiry.
- R4: In split mode a word has H+1 clock toggles, where H = cmp_i[15:8] = 2*bits-1, which gives `bits` rising edges. shift_stb_o pulses for one cycle on each high-to-low toggle, and sclk_o is low while it pulses.
- R5: cmp_flag_o pulses for one cycle at the end of each word. With the lead and trail options off, this is on tick number (L+1)*(H+1) after the start edge.
- R6: If stop_on_cmp_i=1 at the end of a word, the timer goes idle with sclk_o low and gives no further flag. Otherwise it reloads and runs the next word immediately.
- R7: With lead_bit_i=1, each word begins with 2*(L+1) ticks during which sclk_o stays low. The first rising edge then comes at tick 3*(L+1).
- R8: With trail_bit_i=1, each word ends with 2*(L+1) extra ticks after the last toggle, before the flag.
- R9: In wide mode (mode_wide_i=1), the 16-bit counter loaded from cmp_i raises the flag and toggles sclk_o every C+1 ticks, where C = cmp_i. It never pulses shift_stb_o.
- R10: With pin_clk_sel_i=1, a tick is a clock edge at which pin_i is 1 and was 0 at the previous edge. With pin_clk_sel_i=0, every clock edge is a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_wide_i | input | 1 | 1: single 16-bit counter, 0: split divider and edge counter |
| cmp_i | input | 16 | Compare word: low byte divider, high byte edge count |
| trig_i | input | 1 | Trigger input |
| trig_inv_i | input | 1 | Inverts the trigger before use |
| stop_on_cmp_i | input | 1 | Go idle at the end of a word |
| lead_bit_i | input | 1 | Insert a lead bit period before each word |
| trail_bit_i | input | 1 | Insert a trail bit period after each word |
| pin_clk_sel_i | input | 1 | Count rising edges of pin_i instead of clock cycles |
| pin_i | input | 1 | External count input |
| sclk_o | output | 1 | Generated serial clock |
| shift_stb_o | output | 1 | One-cycle shift strobe at each falling serial clock edge |
| cmp_flag_o | output | 1 | One-cycle end-of-word flag |

## Verification
The bench drives random divider values and bit counts, with random lead and trail options, and measures three things: the cycle of the first rising edge, the cycle of the flag, and the number of rising edges and strobes. An off-by-one in the divider reload would stretch every half period. A wrong edge count would produce one bit too many or too few. A lead or trail bit that is dropped or toggles the clock would move the first edge or the flag. Directed cases check the inverted trigger, continuous words followed by a late stop, wide mode, and pin-driven counting. A design that reacts to a held pin level instead of an edge would raise the flag early.

// File: rtl/sbt_pkg.sv
package sbt_pkg;
    typedef enum logic [1:0] {
        PH_LEAD  = 2'd0,
        PH_DATA  = 2'd1,
        PH_TRAIL = 2'd2
    } sbt_phase_e;
endpackage

// File: rtl/sbt_trig_qual.sv
module sbt_trig_qual (
    input  logic trig_i,
    input  logic inv_i,
    output logic act_o
);
    assign act_o = trig_i ^ inv_i;
endmodule

// File: rtl/sbt_tick_sel.sv
module sbt_tick_sel (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_sel_i,
    input  logic pin_i,
    output logic tick_o
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d  = pin_i;
        tick_o = pin_sel_i ? (pin_i & ~pin_q) : 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pin_q <= 1'b0;
        else         pin_q <= pin_d;
    end
endmodule

// File: rtl/sbaud_timer.sv
module sbaud_timer #(
    parameter int HALF_W = 8
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  mode_wide_i,
    input  logic [2*HALF_W-1:0]   cmp_i,
    input  logic                  trig_i,
    input  logic                  trig_inv_i,
    input  logic                  stop_on_cmp_i,
    input  logic                  lead_bit_i,
    input  logic                  trail_bit_i,
    input  logic                  pin_clk_sel_i,
    input  logic                  pin_i,
    output logic                  sclk_o,
    output logic                  shift_stb_o,
    output logic                  cmp_flag_o
);
    import sbt_pkg::*;

    localparam int CMP_W = 2 * HALF_W;

    typedef struct packed {
        logic              run;
        sbt_phase_e        phase;
        logic              half;
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic              sclk;
        logic              stb;
        logic              flag;
    } sbt_state_t;

    sbt_state_t s_d, s_q;
    logic trig_act, tick, word_end;
    logic [CMP_W-1:0] wide_cnt;
    logic [HALF_W-1:0] cmp_lo, cmp_hi;

    assign cmp_lo = cmp_i[HALF_W-1:0];
    assign cmp_hi = cmp_i[CMP_W-1:HALF_W];

    sbt_trig_qual i_trig (
        .trig_i (trig_i),
        .inv_i  (trig_inv_i),
        .act_o  (trig_act)
    );

    sbt_tick_sel i_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_sel_i (pin_clk_sel_i),
        .pin_i     (pin_i),
        .tick_o    (tick)
    );

    always_comb begin
        s_d      = s_q;
        s_d.stb  = 1'b0;
        s_d.flag = 1'b0;
        word_end = 1'b0;
        wide_cnt = {s_q.hi, s_q.lo};
        if (!s_q.run) begin
            if (trig_act) begin
                s_d.run   = 1'b1;
                s_d.lo    = cmp_lo;
                s_d.hi    = cmp_hi;
                s_d.phase = lead_bit_i ? PH_LEAD : PH_DATA;
                s_d.half  = 1'b0;
                s_d.sclk  = 1'b0;
            end
        end else if (tick) begin
            if (mode_wide_i) begin
                // Joined counter: one expiry per compare period
                if (wide_cnt != '0) begin
                    wide_cnt = wide_cnt - CMP_W'(1);
                end else begin
                    wide_cnt = cmp_i;
                    s_d.sclk = ~s_q.sclk;
                    s_d.flag = 1'b1;
                    if (stop_on_cmp_i) begin
                        s_d.run  = 1'b0;
                        s_d.sclk = 1'b0;
                    end
                end
                s_d.hi = wide_cnt[CMP_W-1:HALF_W];
                s_d.lo = wide_cnt[HALF_W-1:0];
            end else if (s_q.lo != '0) begin
                s_d.lo = s_q.lo - HALF_W'(1);
            end else begin
                s_d.lo = cmp_lo;
                unique case (s_q.phase)
                    PH_LEAD: begin
                        if (s_q.half) begin
                            s_d.half  = 1'b0;
                            s_d.phase = PH_DATA;
                        end else begin
                            s_d.half = 1'b1;
                        end
                    end
                    PH_DATA: begin
                        s_d.sclk = ~s_q.sclk;
                        s_d.stb  = s_q.sclk;
                        if (s_q.hi == '0) begin
                            if (trail_bit_i) begin
                                s_d.phase = PH_TRAIL;
                                s_d.half  = 1'b0;
                            end else begin
                                word_end = 1'b1;
                            end
                        end else begin
                            s_d.hi = s_q.hi - HALF_W'(1);
                        end
                    end
                    PH_TRAIL: begin
                        if (s_q.half) word_end = 1'b1;
                        else          s_d.half = 1'b1;
                    end
                    default: s_d.phase = PH_DATA;
                endcase
                if (word_end) begin
                    s_d.flag  = 1'b1;
                    s_d.hi    = cmp_hi;
                    s_d.half  = 1'b0;
                    s_d.phase = lead_bit_i ? PH_LEAD : PH_DATA;
                    if (stop_on_cmp_i) begin
                        s_d.run  = 1'b0;
                        s_d.sclk = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{run: 1'b0, phase: PH_DATA, half: 1'b0, hi: '0, lo: '0,
                     sclk: 1'b0, stb: 1'b0, flag: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign sclk_o      = s_q.sclk;
    assign shift_stb_o = s_q.stb;
    assign cmp_flag_o  = s_q.flag;
endmodule

// File: rtl/sbaud_timer_chk.sv
module sbaud_timer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic run_q,
    input logic mode_wide_i,
    input logic trig_i,
    input logic trig_inv_i,
    input logic stop_on_cmp_i,
    input logic sclk_o,
    input logic shift_stb_o,
    input logic cmp_flag_o
);
    p_reset_quiet_r1: assert property (@(posedge clk_i)
        $rose(rst_ni) |-> (!sclk_o && !shift_stb_o && !cmp_flag_o && !run_q));

    p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_q && !(trig_i ^ trig_inv_i)) |=> !run_q);

    p_stb_low_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_stb_o |-> !sclk_o);

    p_flag_running_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmp_flag_o |-> $past(run_q));

    p_stop_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmp_flag_o && $past(stop_on_cmp_i)) |-> (!run_q && !sclk_o));

    p_wide_nostb_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_stb_o |-> !$past(mode_wide_i));
endmodule

bind sbaud_timer sbaud_timer_chk i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .run_q         (s_q.run),
    .mode_wide_i   (mode_wide_i),
    .trig_i        (trig_i),
    .trig_inv_i    (trig_inv_i),
    .stop_on_cmp_i (stop_on_cmp_i),
    .sclk_o        (sclk_o),
    .shift_stb_o   (shift_stb_o),
    .cmp_flag_o    (cmp_flag_o)
);

// File: tb/test_sbaud_timer.sv
module test_sbaud_timer;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wide = 1'b0;
    logic [15:0] cmp = '0;
    logic trig = 1'b0, inv = 1'b0, stop = 1'b1, lead = 1'b0, trail = 1'b0;
    logic psel = 1'b0, pin = 1'b0;
    logic sclk, stb, flag;

    int n_chk = 0, n_bad = 0;
    int flag_cnt = 0, stb_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbaud_timer i_sbaud_timer (
        .clk_i(clk), .rst_ni(rst_n), .mode_wide_i(wide), .cmp_i(cmp),
        .trig_i(trig), .trig_inv_i(inv), .stop_on_cmp_i(stop),
        .lead_bit_i(lead), .trail_bit_i(trail), .pin_clk_sel_i(psel),
        .pin_i(pin), .sclk_o(sclk), .shift_stb_o(stb), .cmp_flag_o(flag)
    );

    always @(negedge clk) begin
        if (flag) flag_cnt++;
        if (stb)  stb_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int word_ticks(int l, int h, bit s, bit p);
        return (l + 1) * (h + 1 + 2 * int'(s) + 2 * int'(p));
    endfunction

    function automatic int first_rise(int l, bit s);
        return (l + 1) * (1 + 2 * int'(s));
    endfunction

    task automatic start_timer();
        @(negedge clk) trig = ~inv;
        @(posedge clk);
        @(negedge clk) trig = inv;
    endtask

    // One word in split mode, stop at end; measure edges, strobes, flag time
    task automatic one_word(input int l, input int bits, input bit s, input bit p);
        int c = 0, rises = 0, fr = 0, s0, f0;
        bit prev = 0;
        int h = 2 * bits - 1;
        @(negedge clk);
        wide = 0; psel = 0; stop = 1; lead = s; trail = p;
        cmp = {8'(h), 8'(l)};
        s0 = stb_cnt; f0 = flag_cnt;
        start_timer();
        while (c < 5000) begin
            @(posedge clk); #1; c++;
            if (sclk && !prev) begin rises++; if (fr == 0) fr = c; end
            prev = sclk;
            if (flag) break;
        end
        chk(fr == first_rise(l, s), "R3/R7 first rise", fr, first_rise(l, s));
        chk(c == word_ticks(l, h, s, p), "R5/R8 flag tick", c, word_ticks(l, h, s, p));
        chk(rises == bits, "R4 rising edges", rises, bits);
        repeat (2) @(negedge clk);
        chk(stb_cnt - s0 == bits, "R4 strobes", stb_cnt - s0, bits);
        repeat (2 * (l + 1) + 4) @(negedge clk);
        chk(flag_cnt - f0 == 1 && !sclk, "R6 stopped after word", flag_cnt - f0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int c, f1, s0, f0;
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!sclk && !stb && !flag, "R1 reset outputs", {sclk, stb, flag}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sclk && flag_cnt == 0, "R1 idle after reset", flag_cnt, 0);

        // R2: inactive trigger (inverted polarity, input high) keeps idle
        inv = 1; trig = 1; cmp = 16'h0F00;
        repeat (30) @(negedge clk);
        chk(flag_cnt == 0 && !sclk, "R2 inactive trigger", flag_cnt, 0);
        // R2: inverted trigger, active low, starts a word
        one_word(0, 8, 0, 0);
        inv = 0; trig = 0;

        // Directed corners
        one_word(0, 1, 0, 0);
        one_word(2, 8, 1, 1);
        one_word(1, 4, 1, 0);
        one_word(3, 2, 0, 1);

        // Random words
        for (int k = 0; k < 10; k++) begin
            one_word(int'($urandom % 5), 1 + int'($urandom % 8),
                     1'($urandom % 2), 1'($urandom % 2));
        end

        // R6: continuous words, then late stop
        @(negedge clk);
        wide = 0; stop = 0; lead = 0; trail = 0; cmp = {8'd3, 8'd1};
        f0 = flag_cnt;
        start_timer();
        c = 0; f1 = 0;
        while (c < 200) begin
            @(posedge clk); #1; c++;
            if (flag) begin
                if (f1 == 0) f1 = c;
                else break;
            end
        end
        chk(f1 == 8, "R5 first word flag", f1, 8);
        chk(c - f1 == 8, "R6 next word runs", c - f1, 8);
        @(negedge clk) stop = 1;
        repeat (12) @(negedge clk);
        chk(flag_cnt - f0 == 3 && !sclk, "R6 late stop", flag_cnt - f0, 3);
        repeat (10) @(negedge clk);
        chk(flag_cnt - f0 == 3, "R6 stays idle", flag_cnt - f0, 3);

        // R9: wide mode, C = 300 (above one byte)
        @(negedge clk);
        wide = 1; stop = 0; cmp = 16'd300;
        s0 = stb_cnt;
        start_timer();
        c = 0; f1 = 0;
        while (c < 2000) begin
            @(posedge clk); #1; c++;
            if (flag) begin
                if (f1 == 0) begin
                    f1 = c;
                    chk(sclk, "R9 toggle on expiry", int'(sclk), 1);
                end else break;
            end
        end
        chk(f1 == 301, "R9 first expiry", f1, 301);
        chk(c - f1 == 301, "R9 period", c - f1, 301);
        @(negedge clk) stop = 1;
        repeat (310) @(negedge clk);
        chk(stb_cnt == s0, "R9 no strobe", stb_cnt - s0, 0);
        chk(!sclk, "R6 wide stop low", int'(sclk), 0);

        // R10: pin-driven count, wide mode, C = 3 -> flag on 4th rising edge
        @(negedge clk);
        psel = 1; stop = 1; cmp = 16'd3; pin = 0;
        f0 = flag_cnt;
        start_timer();
        // held-high pin must count once only
        @(negedge clk) pin = 1;
        repeat (6) @(negedge clk);
        pin = 0;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk) pin = 1;
            @(negedge clk) pin = 0;
            repeat (3) @(negedge clk);
        end
        chk(flag_cnt == f0, "R10 no flag before last edge", flag_cnt - f0, 0);
        @(negedge clk) pin = 1;
        @(negedge clk) pin = 0;
        repeat (2) @(negedge clk);
        chk(flag_cnt - f0 == 1, "R10 flag on last edge", flag_cnt - f0, 1);

        // R10: pin-driven split mode, L=0, one bit word: 2 edges
        @(negedge clk);
        wide = 0; cmp = {8'd1, 8'd0}; f0 = flag_cnt;
        start_timer();
        @(negedge clk) pin = 1;
        @(negedge clk) pin = 0;
        repeat (4) @(negedge clk);
        chk(sclk && flag_cnt == f0, "R10 split first edge", int'(sclk), 1);
        @(negedge clk) pin = 1;
        @(negedge clk) pin = 0;
        repeat (2) @(negedge clk);
        chk(flag_cnt - f0 == 1 && !sclk, "R10 split word end", flag_cnt - f0, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule